// File: doc/BRIEF.md
# Interrupt Return Sequencer with Fast-Interrupt Mode

This block carries out the interrupt-return instruction of a small 8-bit core and the matching fast-interrupt entry step. It holds the program counter, the instruction pointer, the stack pointer, the flags byte, a shadow copy of the flags and the global interrupt enable. When decode presents the return opcode, the block looks at the fast-interrupt status bit in FLAGS and picks one of two paths. The stack path takes a fixed number of cycles and pulls the flags and a 16-bit return address from a byte-wide stack through a synchronous read port. The register path takes half as many cycles and does not touch memory.

On a fast interrupt the program counter and instruction pointer trade places. Execution jumps to the service routine address held in the instruction pointer, and the return address waits there. The fast return trades them back, so the instruction pointer again points at the service routine for the next fast interrupt. The rest of the core loads the owned registers through a simple write port, but only while no sequence is running.

Top module: `iret_seq`

## Requirements
- R1: After reset, pc, ip, sp, flags, shadowFlags, gie, busy, done and memRd are all zero.
- R2: A sequence starts only at a clock edge where the block is idle, opValid is high and opcode equals 0xBF. Any other opcode, and any opcode presented while busy, changes nothing.
- R3: The path is chosen at the start edge from flags bit 1 (the fast status bit). A 0 selects the stack path and a 1 selects the register path.
- R4: Stack path, with cycle 1 the first cycle after the start edge. In cycle 1 memRd is high with memAddr equal to sp. At the end of cycle 2, flags takes the returned byte and sp increments by 1. In cycle 3 a read is made at sp, which supplies the high byte of the return address. In cycle 4 a read is made at sp+1, which supplies the low byte. At the end of cycle 5, pc takes the 16-bit value and sp increases by 2. Read data arrives one cycle after memRd, and all sp arithmetic wraps modulo 2^16.
- R5: Register path. At the end of cycle 1, pc and ip swap and flags takes shadowFlags with bit 1 forced to 0. memRd stays low for the whole sequence.
- R6: Both paths set gie at the end of the done cycle.
- R7: Fast entry happens when the block is idle, gie is 1, fastIrq is high and no return starts at that edge. In one edge, pc and ip swap, shadowFlags takes the old flags, flags bit 1 is set and gie is cleared.
- R8: done is high only in cycle 12 of the stack path and only in cycle 6 of the register path. busy is high from cycle 1 through the done cycle.
- R9: A fastIrq held during a sequence, including its done cycle, is not taken before the first edge after the done cycle.
- R10: At an edge where the block is idle and no sequence or entry starts, a wrEn write loads the target given by wrSel: 0 loads pc, 1 loads ip, 2 loads sp, 3 loads flags from wrData[7:0], and 4 loads gie from wrData[0]. Writes while busy are ignored.
- R11: An entry followed by a register-path return leaves ip holding the service routine address it held before the entry, and leaves pc holding the interrupted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Decoded opcode is valid this cycle |
| opcode | input | 8 | Decoded opcode byte |
| fastIrq | input | 1 | Fast interrupt request (level) |
| wrEn | input | 1 | Register write strobe from the core |
| wrSel | input | 3 | Write target: 0 pc, 1 ip, 2 sp, 3 flags, 4 gie |
| wrData | input | 16 | Write data |
| memRd | output | 1 | Stack read request |
| memAddr | output | 16 | Stack read address |
| memData | input | 8 | Read data, valid one cycle after memRd |
| pc | output | 16 | Program counter |
| ip | output | 16 | Instruction pointer |
| sp | output | 16 | Stack pointer |
| flags | output | 8 | Flags byte, bit 1 is the fast status bit |
| shadowFlags | output | 8 | Flags saved at fast entry |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | A return sequence is running |
| done | output | 1 | Final cycle of a return sequence |

## Verification
The hardest case to reach is a fast request that stays high through the last cycle of a return. It has to be held off at the done edge, because gie only becomes 1 at that edge, and then taken at the very next edge. The stimulus gets there by entering through a fast interrupt and raising fastIrq partway through the following register-path return. It then holds the request until the entry shows at the ports. A second hard case is a stack return whose pointer crosses the top of the address space. This case is set up by writing sp to 0xFFFE and clearing the fast status bit before issuing the opcode.

// File: rtl/iret_pkg.sv
package iret_pkg;

  typedef enum logic [2:0] {
    WR_PC    = 3'd0,
    WR_IP    = 3'd1,
    WR_SP    = 3'd2,
    WR_FLAGS = 3'd3,
    WR_GIE   = 3'd4
  } wrSel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_STACK = 2'd1,
    SEQ_REG  = 2'd2
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeEntry;
    logic wrAllow;
    logic addrPlus1;
    logic ldFlagsMem;
    logic ldPcHi;
    logic ldPcLo;
    logic regRestore;
    logic setGie;
  } iretStrobes_t;

endpackage

// File: rtl/iret_ctrl.sv
module iret_ctrl
  import iret_pkg::*;
#(
  parameter int            OPC_W       = 8,
  parameter logic [OPC_W-1:0] RET_OPCODE = 8'hBF,
  parameter int            STACK_CYCLES = 12,
  parameter int            REG_CYCLES   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             fastIrq,
  input  logic             fisNow,
  input  logic             gieNow,
  output iretStrobes_t     st,
  output logic             memRd,
  output logic             busy,
  output logic             done
);

  localparam int MAX_CYCLES = (STACK_CYCLES > REG_CYCLES) ? STACK_CYCLES : REG_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] STACK_LEN = CNT_W'(STACK_CYCLES);
  localparam logic [CNT_W-1:0] REG_LEN   = CNT_W'(REG_CYCLES);
  // Step positions of the stack path
  localparam logic [CNT_W-1:0] STEP_RD_FLAGS = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP_LD_FLAGS = CNT_W'(2);
  localparam logic [CNT_W-1:0] STEP_RD_HI    = CNT_W'(3);
  localparam logic [CNT_W-1:0] STEP_RD_LO    = CNT_W'(4);
  localparam logic [CNT_W-1:0] STEP_LD_PC    = CNT_W'(5);
  localparam logic [CNT_W-1:0] STEP_SWAP     = CNT_W'(1);

  seqState_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] seqLen;
  logic            startHit;
  logic            entryHit;
  logic            idle;

  assign idle     = (state == SEQ_IDLE);
  assign startHit = idle && opValid && (opcode == RET_OPCODE);
  assign entryHit = idle && !startHit && fastIrq && gieNow;
  assign seqLen   = (state == SEQ_STACK) ? STACK_LEN : REG_LEN;
  assign busy     = !idle;
  assign done     = !idle && (cnt == seqLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else if (startHit) begin
      state <= fisNow ? SEQ_REG : SEQ_STACK;
      cnt   <= CNT_W'(1);
    end else if (!idle) begin
      if (done) begin
        state <= SEQ_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    st       = '0;
    memRd    = 1'b0;
    st.takeEntry = entryHit;
    st.wrAllow   = idle && !startHit && !entryHit;
    st.setGie    = done;
    if (state == SEQ_STACK) begin
      if (cnt == STEP_RD_FLAGS) memRd = 1'b1;
      if (cnt == STEP_LD_FLAGS) st.ldFlagsMem = 1'b1;
      if (cnt == STEP_RD_HI)    memRd = 1'b1;
      if (cnt == STEP_RD_LO) begin
        memRd        = 1'b1;
        st.addrPlus1 = 1'b1;
        st.ldPcHi    = 1'b1;
      end
      if (cnt == STEP_LD_PC)    st.ldPcLo = 1'b1;
    end else if (state == SEQ_REG) begin
      if (cnt == STEP_SWAP)     st.regRestore = 1'b1;
    end
  end

  // R8: done only while busy, and it ends the sequence
  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  // R2: only the return opcode starts a sequence
  p_start_needs_ret_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(opValid && opcode == RET_OPCODE)) |=> !busy);
  // R5: register path never reads memory
  p_reg_no_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(fisNow) && $rose(busy)) |-> !memRd);

endmodule

// File: rtl/iret_dpath.sv
module iret_dpath
  import iret_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int FIS_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  iretStrobes_t      st,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] shadowFlags,
  output logic              gie
);

  localparam logic [DATA_W-1:0] FIS_MASK = DATA_W'(1) << FIS_BIT;

  logic [DATA_W-1:0] pcHi;
  logic              wrGo;

  assign wrGo    = st.wrAllow && wrEn;
  assign memAddr = sp + ADDR_W'(st.addrPlus1);

  // pc and ip
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
      ip <= '0;
    end else if (st.takeEntry || st.regRestore) begin
      pc <= ip;
      ip <= pc;
    end else if (st.ldPcLo) begin
      pc <= {pcHi, memData};
    end else if (wrGo && wrSel == WR_PC) begin
      pc <= wrData;
    end else if (wrGo && wrSel == WR_IP) begin
      ip <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pcHi <= '0;
    else if (st.ldPcHi)   pcHi <= memData;
  end

  // sp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sp <= '0;
    else if (st.ldFlagsMem)             sp <= sp + ADDR_W'(1);
    else if (st.ldPcLo)                 sp <= sp + ADDR_W'(2);
    else if (wrGo && wrSel == WR_SP)    sp <= wrData;
  end

  // flags and shadow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags       <= '0;
      shadowFlags <= '0;
    end else if (st.takeEntry) begin
      shadowFlags <= flags;
      flags       <= flags | FIS_MASK;
    end else if (st.regRestore) begin
      flags <= shadowFlags & ~FIS_MASK;
    end else if (st.ldFlagsMem) begin
      flags <= memData;
    end else if (wrGo && wrSel == WR_FLAGS) begin
      flags <= wrData[DATA_W-1:0];
    end
  end

  // global enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         gie <= 1'b0;
    else if (st.takeEntry)             gie <= 1'b0;
    else if (st.setGie)                gie <= 1'b1;
    else if (wrGo && wrSel == WR_GIE)  gie <= wrData[0];
  end

  // R7: entry marks fast status and masks interrupts
  p_entry_marks_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.takeEntry |=> (flags[FIS_BIT] && !gie));
  // R6: return re-enables interrupts
  p_gie_on_ret_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.setGie |=> gie);
  // R9: enable cannot change mid-sequence
  p_gie_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!st.setGie && !st.takeEntry && !st.wrAllow) |=> $stable(gie));
  // R4: sp moves only at its two stack steps or by a write
  p_sp_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!st.ldFlagsMem && !st.ldPcLo && !st.wrAllow) |=> $stable(sp));
  // R5: register restore leaves fast status clear
  p_restore_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.regRestore |=> !flags[FIS_BIT]);

endmodule

// File: rtl/iret_seq.sv
module iret_seq
  import iret_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          FIS_BIT      = 1,
  parameter logic [7:0]  RET_OPCODE   = 8'hBF,
  parameter int          STACK_CYCLES = 12,
  parameter int          REG_CYCLES   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opcode,
  input  logic              fastIrq,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] shadowFlags,
  output logic              gie,
  output logic              busy,
  output logic              done
);

  iretStrobes_t strobes;

  iret_ctrl #(
    .OPC_W(8), .RET_OPCODE(RET_OPCODE),
    .STACK_CYCLES(STACK_CYCLES), .REG_CYCLES(REG_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .fastIrq(fastIrq), .fisNow(flags[FIS_BIT]), .gieNow(gie),
    .st(strobes), .memRd(memRd), .busy(busy), .done(done)
  );

  iret_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIS_BIT(FIS_BIT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .st(strobes), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .memData(memData), .memAddr(memAddr), .pc(pc),
    .ip(ip), .sp(sp), .flags(flags), .shadowFlags(shadowFlags), .gie(gie)
  );

endmodule

// File: tb/iret_seq_tb.sv
module iret_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        fastIrq = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = 3'd0;
  logic [15:0] wrData = 16'h0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [7:0]  memData = 8'h00;
  logic [15:0] pc, ip, sp;
  logic [7:0]  flags, shadowFlags;
  logic        gie, busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  iret_seq dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .fastIrq(fastIrq), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .memRd(memRd), .memAddr(memAddr), .memData(memData), .pc(pc),
    .ip(ip), .sp(sp), .flags(flags), .shadowFlags(shadowFlags),
    .gie(gie), .busy(busy), .done(done)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  // memory with one cycle of latency
  always @(posedge clk) memData <= memByte(memAddr);

  // reference model
  int          mMode = 0;  // 0 idle, 1 stack, 2 register
  int          mCnt = 0;
  logic [15:0] mPc = 0, mIp = 0, mSp = 0, mSp0 = 0;
  logic [7:0]  mFlags = 0, mShadow = 0;
  logic        mGie = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mPc = 0; mIp = 0; mSp = 0; mSp0 = 0;
      mFlags = 0; mShadow = 0; mGie = 0;
    end else if (mMode == 0) begin
      if (opValid && opcode == 8'hBF) begin
        mMode = mFlags[1] ? 2 : 1; mCnt = 1; mSp0 = mSp;
      end else if (fastIrq && mGie) begin
        logic [15:0] t;
        t = mPc; mPc = mIp; mIp = t;
        mShadow = mFlags; mFlags = mFlags | 8'h02; mGie = 0;
      end else if (wrEn) begin
        case (wrSel)
          3'd0: mPc = wrData;
          3'd1: mIp = wrData;
          3'd2: mSp = wrData;
          3'd3: mFlags = wrData[7:0];
          3'd4: mGie = wrData[0];
          default: ;
        endcase
      end
    end else begin
      if (mMode == 1 && mCnt == 2) begin
        mFlags = memByte(mSp0); mSp = mSp0 + 16'd1;
      end
      if (mMode == 1 && mCnt == 5) begin
        mPc = {memByte(mSp0 + 16'd1), memByte(mSp0 + 16'd2)};
        mSp = mSp0 + 16'd3;
      end
      if (mMode == 2 && mCnt == 1) begin
        logic [15:0] t;
        t = mPc; mPc = mIp; mIp = t;
        mFlags = mShadow & 8'hFD;
      end
      if (mCnt == ((mMode == 1) ? 12 : 6)) begin
        mMode = 0; mCnt = 0; mGie = 1;
      end else begin
        mCnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic eBusy, eDone, eRd;
      logic [15:0] eAddr;
      eBusy = (mMode != 0);
      eDone = eBusy && (mCnt == ((mMode == 1) ? 12 : 6));
      eRd   = (mMode == 1) && (mCnt == 1 || mCnt == 3 || mCnt == 4);
      eAddr = (mCnt == 1) ? mSp0 : (mCnt == 3) ? mSp0 + 16'd1 : mSp0 + 16'd2;
      chk("R4 pc", pc, mPc);
      chk("R5 ip", ip, mIp);
      chk("R4 sp", sp, mSp);
      chk("R3 flags", {8'h0, flags}, {8'h0, mFlags});
      chk("R7 shadowFlags", {8'h0, shadowFlags}, {8'h0, mShadow});
      chk("R6 gie", {15'h0, gie}, {15'h0, mGie});
      chk("R8 busy", {15'h0, busy}, {15'h0, eBusy});
      chk("R8 done", {15'h0, done}, {15'h0, eDone});
      chk("R4 memRd", {15'h0, memRd}, {15'h0, eRd});
      if (eRd) chk("R4 memAddr", memAddr, eAddr);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issueOp(input logic [7:0] op);
    opValid = 1'b1; opcode = op;
    @(negedge clk);
    opValid = 1'b0; opcode = 8'h00;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish();
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 pc", pc, 16'h0); chk("R1 sp", sp, 16'h0);
    chk("R1 flags", {8'h0, flags}, 16'h0);
    chk("R1 gie busy done memRd", {12'h0, gie, busy, done, memRd}, 16'h0);
    rstN = 1'b1;
    step(1);
    // R10 register writes while idle
    wr(3'd0, 16'h0500); wr(3'd1, 16'h0100); wr(3'd2, 16'h1234);
    wr(3'd3, 16'h0000); wr(3'd4, 16'h0001);
    chk("R10 pc", pc, 16'h0500); chk("R10 ip", ip, 16'h0100);
    chk("R10 sp", sp, 16'h1234); chk("R10 gie", {15'h0, gie}, 16'h1);
    // R2 other opcodes ignored
    issueOp(8'hBE); issueOp(8'h3F);
    chk("R2 busy after other opcodes", {15'h0, busy}, 16'h0);
    chk("R2 pc unchanged", pc, 16'h0500);
    // R7 fast entry
    fastIrq = 1'b1; step(1); fastIrq = 1'b0;
    chk("R7 pc", pc, 16'h0100); chk("R7 ip", ip, 16'h0500);
    chk("R7 flags", {8'h0, flags}, 16'h0002);
    chk("R7 gie", {15'h0, gie}, 16'h0);
    // R3/R5 register-path return, with ignored stimulus while busy
    issueOp(8'hBF);                 // now in cycle 1
    chk("R3 register path no read", {15'h0, memRd}, 16'h0);
    issueOp(8'hBF);                 // cycle 2, ignored (R2)
    wr(3'd2, 16'h7777);             // cycle 3, ignored (R10)
    fastIrq = 1'b1;
    step(3);                        // cycle 6
    chk("R8 register done", {15'h0, done}, 16'h1);
    chk("R10 write ignored while busy", sp, 16'h1234);
    chk("R11 ip back to routine", ip, 16'h0100);
    chk("R11 pc back to main", pc, 16'h0500);
    step(1);
    chk("R9 entry held at done edge", pc, 16'h0500);
    chk("R6 gie set", {15'h0, gie}, 16'h1);
    step(1);
    fastIrq = 1'b0;
    chk("R9 entry taken next edge", pc, 16'h0100);
    // R4 stack path with wrap
    wr(3'd3, 16'h0000); wr(3'd2, 16'hFFFE);
    issueOp(8'hBF);                 // cycle 1
    chk("R4 first read", {15'h0, memRd}, 16'h1);
    chk("R4 first addr", memAddr, 16'hFFFE);
    step(2);                        // cycle 3
    chk("R4 flags popped", {8'h0, flags}, {8'h0, memByte(16'hFFFE)});
    chk("R4 sp plus one", sp, 16'hFFFF);
    step(1);                        // cycle 4
    chk("R4 wrapped addr", memAddr, 16'h0000);
    step(2);                        // cycle 6
    chk("R4 pc popped", pc, {memByte(16'hFFFF), memByte(16'h0000)});
    chk("R4 sp wrapped", sp, 16'h0001);
    step(5);                        // cycle 11
    chk("R8 not done at 11", {15'h0, done}, 16'h0);
    step(1);                        // cycle 12
    chk("R8 stack done", {15'h0, done}, 16'h1);
    step(1);
    chk("R6 gie after stack return", {15'h0, gie}, 16'h1);
    chk("R8 idle", {15'h0, busy}, 16'h0);
    // further mixed traffic checked by the model
    wr(3'd2, 16'h2000); wr(3'd3, 16'h0000);
    issueOp(8'hBF); step(14);
    issueOp(8'hBF); step(14);
    fastIrq = 1'b1; step(1); fastIrq = 1'b0;
    issueOp(8'hBF); step(8);
    finish();
  end

endmodule